// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one string primitive over byte-wide memory: move, store, load, compare or scan. It can run the primitive a single time, or as a loop governed by a repeat prefix. A request from the issuing logic supplies:

- the primitive and the prefix;
- the element size and the direction flag;
- the count;
- the two index registers and the two segment registers;
- the accumulator and the incoming zero flag.

The sequencer walks the elements through a request/ready memory port. Every transfer on that port is one byte, so a word element costs two transfers.

When the loop ends, the block holds the final count, both index registers, the accumulator and the zero flag on its outputs, and it raises `done` for one cycle. The issuing logic copies these values back into its architectural state. Source elements are addressed through the data segment and the source index. Destination elements are addressed through the extra segment and the destination index.

Top module: `strop_sequencer`

## Requirements
- R1: Each physical address equals segment times 16 plus offset, truncated to 20 bits. Source reads use the data segment with the source index. Destination accesses use the extra segment with the destination index. For example, segment 2000h with offset 0500h gives 20500h, and segment FFFFh with offset 0010h wraps to 00000h.
- R2: After each element, every index register the primitive touched moves by 1 for bytes or 2 for words. It moves up when the direction flag is 0 and down when it is 1, and wraps at 16 bits. Store and scan leave the source index unchanged. Load leaves the destination index unchanged.
- R3: A word element is carried as two byte transfers, low byte first, at offset and then offset+1 (wrapping at 16 bits). While `mem_ack` is low, a pending request keeps its address and direction.
- R4: If a repeat prefix is given (prefix code not 0) and the count is zero at the start, the block makes no memory transfer, returns count 0 and leaves both index registers unchanged.
- R5: The prefix codes are 0 = none, 1 = repeat, 2 = repeat while equal, 3 = repeat while not equal.
  - With code 0, exactly one element runs and the count comes back unchanged.
  - With any other code, the count is tested before each element and decremented by 1 for each element run.
- R6: For compare and scan, the loop stops once the zero flag is 0 (codes 1 and 2) or once it is 1 (code 3). For move, store and load, codes 2 and 3 behave like code 1, and the zero flag has no effect on them.
- R7: The primitive codes are 0 move, 1 store, 2 load, 3 compare, 4 scan.
  - Move copies each source element to the destination.
  - Store writes the accumulator: its low byte for byte elements, or the whole word.
  - Load replaces only the low accumulator byte for byte elements, or the whole accumulator for words.
  - None of these three changes the zero flag, and only move and store ever write memory.
- R8: Compare sets the zero flag exactly when the source element equals the destination element. Scan sets it exactly when the accumulator equals the destination element. Byte elements compare only the low bytes.
- R9: After reset, `done`, `mem_req`, the count, index, accumulator and zero-flag outputs are all 0. `done` is a single-cycle pulse.
- R10: Primitive codes 5 to 7 finish with a `done` pulse. They make no memory transfer and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request; accepted only while idle |
| op_i | input | 3 | Primitive code |
| rep_i | input | 2 | Repeat prefix code |
| word_i | input | 1 | 1 = word elements, 0 = byte elements |
| dir_i | input | 1 | Direction flag: 0 steps up, 1 steps down |
| cnt_i | input | 16 | Initial count |
| src_i | input | 16 | Initial source index |
| dst_i | input | 16 | Initial destination index |
| dseg_i | input | 16 | Data segment |
| eseg_i | input | 16 | Extra segment |
| acc_i | input | 16 | Initial accumulator |
| zf_i | input | 1 | Initial zero flag |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Ready; a transfer completes when `mem_req` and `mem_ack` are both high |
| cnt_o | output | 16 | Final count |
| src_o | output | 16 | Final source index |
| dst_o | output | 16 | Final destination index |
| acc_o | output | 16 | Final accumulator |
| zf_o | output | 1 | Final zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The primitives are driven across both element sizes, both directions and all four prefix codes. The memory patterns are laid out so that a compare or scan mismatches, or matches, at a known element. This separates early termination from running out the count, and it shows whether the equal and not-equal senses are swapped.

Cross cases cover two things. A plain repeat on a compare must stop like repeat-while-equal, and a while-equal prefix on a move must ignore a clear zero flag. Directed runs add the remaining cases:

- a zero starting count;
- an invalid primitive code;
- an index at FFFFh, to check the 16-bit offset wrap on a word element;
- a segment near the top of the space, to check the 20-bit address wrap.

A memory model that withholds ready on alternate requests checks that each request holds its address and direction while it waits.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [2:0] OP_MOVE  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_LOAD  = 3'd2;
    localparam logic [2:0] OP_CMP   = 3'd3;
    localparam logic [2:0] OP_SCAN  = 3'd4;

    typedef enum logic [1:0] {
        REP_NONE = 2'd0,
        REP_ALL  = 2'd1,
        REP_EQ   = 2'd2,
        REP_NE   = 2'd3
    } rep_e;

    typedef enum logic [1:0] {
        PH_RD_SRC,
        PH_RD_DST,
        PH_WR_DST,
        PH_END
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ACCESS,
        ST_EVAL,
        ST_FIN
    } state_e;

    // first memory phase of one element
    function automatic phase_e first_phase(input logic [2:0] op);
        case (op)
            OP_STORE: return PH_WR_DST;
            OP_SCAN:  return PH_RD_DST;
            default:  return PH_RD_SRC;
        endcase
    endfunction

    // phase following ph for primitive op
    function automatic phase_e next_phase(input logic [2:0] op, input phase_e ph);
        if (ph == PH_RD_SRC && op == OP_MOVE) return PH_WR_DST;
        if (ph == PH_RD_SRC && op == OP_CMP)  return PH_RD_DST;
        return PH_END;
    endfunction

    function automatic logic is_match_op(input logic [2:0] op);
        return (op == OP_CMP) || (op == OP_SCAN);
    endfunction

endpackage

// File: rtl/str_agu.sv
// Physical address for one byte of an element: segment shifted plus offset.
module str_agu #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFF_W + SEG_SHIFT
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic             hi_byte,
    output logic [PA_W-1:0]  addr
);
    logic [OFF_W-1:0] off_b;

    always_comb begin
        off_b = off + OFF_W'(hi_byte);
        addr  = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off_b};
    end
endmodule

// File: rtl/str_ptr_step.sv
// Next value of an index register after one element.
module str_ptr_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] ptr,
    input  logic             word,
    input  logic             dir,
    input  logic             en,
    output logic [OFF_W-1:0] nxt
);
    logic [OFF_W-1:0] mag;

    always_comb begin
        mag = word ? OFF_W'(2) : OFF_W'(1);
        if (!en)
            nxt = ptr;
        else if (dir)
            nxt = ptr - mag;
        else
            nxt = ptr + mag;
    end
endmodule

// File: rtl/str_zcmp.sv
// Zero result of a subtraction, restricted to the element width.
module str_zcmp
    import str_seq_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              word,
    output logic              zero
);
    logic [WORD_W-1:0] diff;

    always_comb begin
        diff = a - b;
        zero = word ? (diff == '0) : (diff[BYTE_W-1:0] == '0);
    end
endmodule

// File: rtl/strop_sequencer.sv
module strop_sequencer
    import str_seq_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFF_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_i,
    input  logic [1:0]        rep_i,
    input  logic              word_i,
    input  logic              dir_i,
    input  logic [OFF_W-1:0]  cnt_i,
    input  logic [OFF_W-1:0]  src_i,
    input  logic [OFF_W-1:0]  dst_i,
    input  logic [OFF_W-1:0]  dseg_i,
    input  logic [OFF_W-1:0]  eseg_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              zf_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [OFF_W-1:0]  cnt_o,
    output logic [OFF_W-1:0]  src_o,
    output logic [OFF_W-1:0]  dst_o,
    output logic [WORD_W-1:0] acc_o,
    output logic              zf_o,
    output logic              done
);
    localparam int NSIDE = 2;   // 0 = source side, 1 = destination side

    state_e            state_q;
    phase_e            ph_q;
    rep_e              rep_q;
    logic [2:0]        op_q;
    logic              word_q, dir_q, zf_q, ran_q, hi_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [OFF_W-1:0]  ptr_q [NSIDE];
    logic [OFF_W-1:0]  seg_q [NSIDE];
    logic [OFF_W-1:0]  ptr_nx [NSIDE];
    logic [NSIDE-1:0]  step_en;
    logic [WORD_W-1:0] acc_q, sbuf_q, dbuf_q, cmp_a;
    logic              side, xfer, last_byte, is_match, zf_stop, cmp_zero;
    rep_e              rep_eff;

    // ---------------- control decode ----------------
    always_comb begin
        is_match = is_match_op(op_q);
        if (rep_q == REP_NONE)      rep_eff = REP_NONE;
        else if (!is_match)         rep_eff = REP_ALL;
        else if (rep_q == REP_ALL)  rep_eff = REP_EQ;
        else                        rep_eff = rep_q;
        zf_stop   = (rep_eff == REP_EQ && !zf_q) || (rep_eff == REP_NE && zf_q);
        side      = (ph_q != PH_RD_SRC);
        xfer      = mem_req && mem_ack;
        last_byte = hi_q || !word_q;
        step_en[0] = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
        step_en[1] = (op_q == OP_MOVE) || (op_q == OP_STORE) || is_match;
        cmp_a     = (op_q == OP_SCAN) ? acc_q : sbuf_q;
    end

    // ---------------- memory port ----------------
    str_agu #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_agu (
        .seg     (seg_q[side]),
        .off     (ptr_q[side]),
        .hi_byte (hi_q),
        .addr    (mem_addr)
    );

    always_comb begin
        mem_req   = (state_q == ST_ACCESS);
        mem_we    = mem_req && (ph_q == PH_WR_DST);
        if (op_q == OP_MOVE)
            mem_wdata = hi_q ? sbuf_q[WORD_W-1:BYTE_W] : sbuf_q[BYTE_W-1:0];
        else
            mem_wdata = hi_q ? acc_q[WORD_W-1:BYTE_W] : acc_q[BYTE_W-1:0];
    end

    // ---------------- index stepping, one per side ----------------
    for (genvar g = 0; g < NSIDE; g++) begin : g_step
        str_ptr_step #(.OFF_W(OFF_W)) u_step (
            .ptr  (ptr_q[g]),
            .word (word_q),
            .dir  (dir_q),
            .en   (step_en[g]),
            .nxt  (ptr_nx[g])
        );
    end

    str_zcmp u_zcmp (
        .a    (cmp_a),
        .b    (dbuf_q),
        .word (word_q),
        .zero (cmp_zero)
    );

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= PH_END;
            rep_q   <= REP_NONE;
            op_q    <= '0;
            word_q  <= 1'b0;
            dir_q   <= 1'b0;
            zf_q    <= 1'b0;
            ran_q   <= 1'b0;
            hi_q    <= 1'b0;
            cnt_q   <= '0;
            acc_q   <= '0;
            sbuf_q  <= '0;
            dbuf_q  <= '0;
            for (int i = 0; i < NSIDE; i++) begin
                ptr_q[i] <= '0;
                seg_q[i] <= '0;
            end
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    op_q     <= op_i;
                    rep_q    <= rep_e'(rep_i);
                    word_q   <= word_i;
                    dir_q    <= dir_i;
                    cnt_q    <= cnt_i;
                    ptr_q[0] <= src_i;
                    ptr_q[1] <= dst_i;
                    seg_q[0] <= dseg_i;
                    seg_q[1] <= eseg_i;
                    acc_q    <= acc_i;
                    zf_q     <= zf_i;
                    ran_q    <= 1'b0;
                    state_q  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (op_q > OP_SCAN) begin
                        state_q <= ST_FIN;
                    end else if (rep_q == REP_NONE ? ran_q
                                 : (cnt_q == '0 || (ran_q && zf_stop))) begin
                        state_q <= ST_FIN;
                    end else begin
                        if (rep_q != REP_NONE) cnt_q <= cnt_q - 1'b1;
                        ph_q    <= first_phase(op_q);
                        hi_q    <= 1'b0;
                        state_q <= ST_ACCESS;
                    end
                end
                ST_ACCESS: if (xfer) begin
                    if (ph_q == PH_RD_SRC) begin
                        if (hi_q) sbuf_q[WORD_W-1:BYTE_W] <= mem_rdata;
                        else      sbuf_q[BYTE_W-1:0]      <= mem_rdata;
                    end else if (ph_q == PH_RD_DST) begin
                        if (hi_q) dbuf_q[WORD_W-1:BYTE_W] <= mem_rdata;
                        else      dbuf_q[BYTE_W-1:0]      <= mem_rdata;
                    end
                    if (!last_byte) begin
                        hi_q <= 1'b1;
                    end else begin
                        hi_q <= 1'b0;
                        ph_q <= next_phase(op_q, ph_q);
                        if (next_phase(op_q, ph_q) == PH_END) state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    for (int i = 0; i < NSIDE; i++) ptr_q[i] <= ptr_nx[i];
                    if (op_q == OP_LOAD) begin
                        acc_q[BYTE_W-1:0] <= sbuf_q[BYTE_W-1:0];
                        if (word_q) acc_q[WORD_W-1:BYTE_W] <= sbuf_q[WORD_W-1:BYTE_W];
                    end
                    if (is_match) zf_q <= cmp_zero;
                    ran_q   <= 1'b1;
                    state_q <= ST_CHECK;
                end
                default: state_q <= ST_IDLE;   // ST_FIN
            endcase
        end
    end

    assign done  = (state_q == ST_FIN);
    assign cnt_o = cnt_q;
    assign src_o = ptr_q[0];
    assign dst_o = ptr_q[1];
    assign acc_o = acc_q;
    assign zf_o  = zf_q;

    // ---------------- assertions ----------------
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));

    a_r4_zero_no_access: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && rep_q != REP_NONE && cnt_q == '0) |=> !mem_req);

    a_r7_write_only_move_store: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (op_q == OP_MOVE || op_q == OP_STORE));

    a_r2_src_kept: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL && (op_q == OP_STORE || op_q == OP_SCAN)) |=> $stable(src_o));

    a_r10_bad_op_no_access: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && op_q > OP_SCAN) |=> !mem_req);

endmodule

// File: tb/strop_sequencer_tb.sv
`timescale 1ns/1ps
module strop_sequencer_tb;

    localparam logic [15:0] DS = 16'h2000;
    localparam logic [15:0] ES = 16'h4000;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  rep;
        logic        word;
        logic        dir;
        logic        zf;
        logic [15:0] cnt;
        logic [15:0] si;
        logic [15:0] di;
        logic [15:0] acc;
        logic [15:0] poff;
        logic [7:0]  pval;
        logic        stall;
        logic [15:0] ecnt;
        logic        ezf;
    } vec_t;

    localparam int NV = 15;
    // op rep word dir zf cnt si di acc poff pval stall | exp cnt, exp zf
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'd5,  16'h0100, 16'h0340, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'd5, 1'b0},
        '{3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 16'd4,  16'h0100, 16'h0340, 16'h0000, 16'hFFFF, 8'h00, 1'b1, 16'd0, 1'b1},
        '{3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 16'd3,  16'h0110, 16'h0350, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'd0, 1'b0},
        '{3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 16'd3,  16'h0100, 16'h0360, 16'hBEEF, 16'hFFFF, 8'h00, 1'b1, 16'd0, 1'b0},
        '{3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 16'd3,  16'h0100, 16'h0300, 16'hAA00, 16'hFFFF, 8'h00, 1'b0, 16'd0, 1'b1},
        '{3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 16'd2,  16'h0104, 16'h0300, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'd2, 1'b0},
        '{3'd3, 2'd2, 1'b0, 1'b0, 1'b1, 16'd8,  16'h0100, 16'h0300, 16'h0000, 16'h0303, 8'hEE, 1'b1, 16'd4, 1'b0},
        '{3'd3, 2'd2, 1'b1, 1'b0, 1'b0, 16'd8,  16'h0100, 16'h0300, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'd0, 1'b1},
        '{3'd3, 2'd3, 1'b0, 1'b0, 1'b0, 16'd6,  16'h0100, 16'h0310, 16'h0000, 16'h0312, 8'h03, 1'b0, 16'd3, 1'b1},
        '{3'd4, 2'd3, 1'b0, 1'b0, 1'b0, 16'd10, 16'h0100, 16'h0300, 16'h0005, 16'hFFFF, 8'h00, 1'b1, 16'd5, 1'b1},
        '{3'd4, 2'd2, 1'b1, 1'b0, 1'b0, 16'd5,  16'h0100, 16'h0300, 16'h0201, 16'hFFFF, 8'h00, 1'b0, 16'd3, 1'b0},
        '{3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 16'd5,  16'h0100, 16'h0300, 16'h0000, 16'h0301, 8'h00, 1'b0, 16'd3, 1'b0},
        '{3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 16'd3,  16'h0100, 16'h0340, 16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'd0, 1'b0},
        '{3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 16'd7,  16'h0100, 16'h0300, 16'h0001, 16'hFFFF, 8'h00, 1'b0, 16'd7, 1'b1},
        '{3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 16'd4,  16'h0103, 16'h0303, 16'h0000, 16'hFFFF, 8'h00, 1'b1, 16'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  rep_i = '0;
    logic        word_i = 1'b0, dir_i = 1'b0, zf_i = 1'b0;
    logic [15:0] cnt_i = '0, src_i = '0, dst_i = '0, dseg_i = '0, eseg_i = '0, acc_i = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = '0;
    logic [15:0] cnt_o, src_o, dst_o, acc_o;
    logic        zf_o, done;

    always #2 clk = ~clk;   // 250 MHz

    strop_sequencer u_dut (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i), .rep_i(rep_i),
        .word_i(word_i), .dir_i(dir_i), .cnt_i(cnt_i), .src_i(src_i), .dst_i(dst_i),
        .dseg_i(dseg_i), .eseg_i(eseg_i), .acc_i(acc_i), .zf_i(zf_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cnt_o(cnt_o), .src_o(src_o), .dst_o(dst_o), .acc_o(acc_o), .zf_o(zf_o), .done(done)
    );

    logic [7:0]  mem     [logic [19:0]];
    logic [7:0]  exp_mem [logic [19:0]];
    logic [19:0] addr_log [2];
    int          nxfer;
    logic        stall_en = 1'b0, stall_t = 1'b0;
    int          total = 0, bad = 0;

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [7:0] rdm(input logic [19:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] rde(input logic [19:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // memory model: answers at the falling edge, optional wait on alternate requests
    always @(negedge clk) begin
        if (mem_req) begin
            mem_rdata = rdm(mem_addr);
            if (stall_en && !stall_t) begin
                mem_ack = 1'b0;
                stall_t = 1'b1;
            end else begin
                mem_ack = 1'b1;
                stall_t = 1'b0;
                if (nxfer < 2) addr_log[nxfer] = mem_addr;
                nxfer = nxfer + 1;
                if (mem_we) mem[mem_addr] = mem_wdata;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] rep, input logic word, input logic dir,
                       input logic zf, input logic [15:0] cnt, input logic [15:0] si, input logic [15:0] di,
                       input logic [15:0] ds, input logic [15:0] es, input logic [15:0] acc, input logic stall);
        int guard;
        @(posedge clk); #1;
        nxfer = 0; stall_en = stall; stall_t = 1'b0;
        op_i = op; rep_i = rep; word_i = word; dir_i = dir; zf_i = zf; cnt_i = cnt;
        src_i = si; dst_i = di; dseg_i = ds; eseg_i = es; acc_i = acc; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 4000);
        if (!done) chk(1'b0, "watchdog run", 32'(guard), 32'd0);
    endtask

    task automatic init_mem(input logic [15:0] poff, input logic [7:0] pval);
        mem.delete();
        for (int i = 0; i < 64; i++) begin
            mem[pa(DS, 16'h0100 + 16'(i))] = 8'(i + 1);
            mem[pa(ES, 16'h0300 + 16'(i))] = 8'(i + 1);
        end
        mem[pa(ES, poff)] = pval;
        exp_mem = mem;
    endtask

    // independent model of one request on exp_mem
    task automatic model(input vec_t v, output logic [15:0] mc, output logic [15:0] ms,
                         output logic [15:0] md, output logic [15:0] ma, output logic mz);
        logic [15:0] c, s, d, a, stp, x, y;
        logic z, eqm;
        int n;
        c = v.cnt; s = v.si; d = v.di; a = v.acc; z = v.zf;
        n = v.word ? 2 : 1;
        stp = v.dir ? 16'(-n) : 16'(n);
        eqm = (v.rep != 2'd3);
        for (int it = 0; it < 70000; it++) begin
            if (v.rep != 2'd0) begin
                if (c == 16'd0) break;
                c = c - 16'd1;
            end else if (it > 0) break;
            x = {v.word ? rde(pa(DS, s + 16'd1)) : 8'h00, rde(pa(DS, s))};
            y = {v.word ? rde(pa(ES, d + 16'd1)) : 8'h00, rde(pa(ES, d))};
            case (v.op)
                3'd0: begin
                    for (int k = 0; k < n; k++) exp_mem[pa(ES, d + 16'(k))] = rde(pa(DS, s + 16'(k)));
                    s = s + stp; d = d + stp;
                end
                3'd1: begin
                    exp_mem[pa(ES, d)] = a[7:0];
                    if (v.word) exp_mem[pa(ES, d + 16'd1)] = a[15:8];
                    d = d + stp;
                end
                3'd2: begin
                    if (v.word) a = x; else a[7:0] = x[7:0];
                    s = s + stp;
                end
                3'd3: begin
                    z = (x == y);
                    s = s + stp; d = d + stp;
                end
                default: begin
                    z = v.word ? (a == y) : (a[7:0] == y[7:0]);
                    d = d + stp;
                end
            endcase
            if (v.rep != 2'd0 && (v.op == 3'd3 || v.op == 3'd4)) begin
                if (eqm && !z) break;
                if (!eqm && z) break;
            end
        end
        mc = c; ms = s; md = d; ma = a; mz = z;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] mc, ms, md, ma;
        logic mz;
        int miss;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(!done && !mem_req, "R9 reset done/req", {30'd0, done, mem_req}, 32'd0);
        chk(cnt_o == 0 && src_o == 0 && dst_o == 0 && acc_o == 0 && !zf_o,
            "R9 reset outputs", {cnt_o, acc_o}, 32'd0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            init_mem(VEC[i].poff, VEC[i].pval);
            model(VEC[i], mc, ms, md, ma, mz);
            run(VEC[i].op, VEC[i].rep, VEC[i].word, VEC[i].dir, VEC[i].zf, VEC[i].cnt,
                VEC[i].si, VEC[i].di, DS, ES, VEC[i].acc, VEC[i].stall);
            chk(cnt_o == VEC[i].ecnt, $sformatf("R5 R6 count vec%0d", i), 32'(cnt_o), 32'(VEC[i].ecnt));
            chk(zf_o == VEC[i].ezf, $sformatf("R6 R8 zf vec%0d", i), 32'(zf_o), 32'(VEC[i].ezf));
            chk(src_o == ms && dst_o == md, $sformatf("R2 indices vec%0d", i),
                {src_o, dst_o}, {ms, md});
            chk(acc_o == ma, $sformatf("R7 acc vec%0d", i), 32'(acc_o), 32'(ma));
            chk(cnt_o == mc && zf_o == mz, $sformatf("R5 model vec%0d", i), {15'd0, zf_o, cnt_o}, {15'd0, mz, mc});
            miss = (mem.num() == exp_mem.num()) ? 0 : 1;
            foreach (exp_mem[k]) if (!mem.exists(k) || mem[k] != exp_mem[k]) miss++;
            chk(miss == 0, $sformatf("R1 R3 R7 memory vec%0d", i), 32'(miss), 32'd0);
            @(negedge clk);
            chk(!done, $sformatf("R9 done pulse vec%0d", i), 32'(done), 32'd0);
        end

        // R4: repeat with count zero
        init_mem(16'hFFFF, 8'h00);
        run(3'd0, 2'd1, 1'b1, 1'b0, 1'b0, 16'd0, 16'h0100, 16'h0340, DS, ES, 16'h0, 1'b0);
        chk(nxfer == 0, "R4 no transfer", 32'(nxfer), 32'd0);
        chk(cnt_o == 0 && src_o == 16'h0100 && dst_o == 16'h0340, "R4 state unchanged",
            {src_o, dst_o}, {16'h0100, 16'h0340});

        // R10: undefined primitive code
        run(3'd6, 2'd1, 1'b0, 1'b0, 1'b0, 16'd3, 16'h0100, 16'h0340, DS, ES, 16'h0, 1'b0);
        chk(nxfer == 0 && cnt_o == 16'd3, "R10 undefined op", {nxfer[15:0], cnt_o}, {16'd0, 16'd3});

        // R1 + R7: byte load at 2000:0500, high accumulator byte kept
        mem.delete();
        mem[20'h20500] = 8'h38;
        run(3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 16'd0, 16'h0500, 16'h0000, 16'h2000, ES, 16'hAA00, 1'b0);
        chk(addr_log[0] == 20'h20500, "R1 physical address", 32'(addr_log[0]), 32'h20500);
        chk(acc_o == 16'hAA38, "R7 byte load keeps high", 32'(acc_o), 32'hAA38);
        chk(src_o == 16'h0501, "R2 byte step up", 32'(src_o), 32'h0501);

        // R3 + R2: word load across offset wrap
        mem.delete();
        mem[20'h2FFFF] = 8'h11;
        mem[20'h20000] = 8'h22;
        run(3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 16'd0, 16'hFFFF, 16'h0000, 16'h2000, ES, 16'h0, 1'b1);
        chk(addr_log[0] == 20'h2FFFF && addr_log[1] == 20'h20000, "R3 low byte first, offset wrap",
            32'(addr_log[1]), 32'h20000);
        chk(acc_o == 16'h2211, "R3 word assembly", 32'(acc_o), 32'h2211);
        chk(src_o == 16'h0001, "R2 word step wraps", 32'(src_o), 32'h0001);

        // R1: 20-bit wrap on store, direction down
        mem.delete();
        run(3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 16'd9, 16'h0000, 16'h0010, DS, 16'hFFFF, 16'h12C3, 1'b0);
        chk(addr_log[0] == 20'h00000, "R1 address wrap", 32'(addr_log[0]), 32'h0);
        chk(rdm(20'h00000) == 8'hC3 && nxfer == 1, "R7 byte store", 32'(rdm(20'h00000)), 32'hC3);
        chk(dst_o == 16'h000F && zf_o && cnt_o == 16'd9, "R2 R5 step down, flags kept",
            {dst_o, cnt_o}, {16'h000F, 16'd9});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule